// File: doc/BRIEF.md
# Stepped-System I/O Sequencer

This block is the system-level controller that sits between a single-stepped processor, a simple dual-port data RAM with one clock of read latency, and a small user front end of three debounced buttons. After reset it copies a program image, one word per clock, from a ROM with combinational read into the instruction memory. When the copy is done it enters its idle state. In that state the processor owns the data RAM port.

Each step pulse seen while idle starts a refresh pass of three states. The pass updates a 32-bit output buffer from one fixed RAM word and writes a 32-bit input buffer into another fixed RAM word. Memory-mapped I/O therefore stays consistent with what the processor stores and loads. Button presses are turned into code values in the input buffer, and each press also raises a one-cycle interrupt request.

The states are `ST_LOAD` (ROM copy), `ST_RUN` (idle), `ST_LOAD_OUT` (address the output word), `ST_SHOW_OUT` (capture the returned data) and `ST_PUSH_IN` (write the input buffer). The transitions are:

- `ST_LOAD` to `ST_RUN` after the last ROM word.
- `ST_RUN` to `ST_LOAD_OUT` when the step pulse is high.
- `ST_LOAD_OUT` to `ST_SHOW_OUT` to `ST_PUSH_IN` to `ST_RUN`, unconditionally.

Top module: `mmio_step_seq`

## Requirements
- R1: While and right after reset, `out_buf` and `in_buf` are zero and `irq` is low.
- R2: Starting at the first clock edge after reset is released, exactly `ROM_DEPTH` instruction-memory writes are made, one per clock, to addresses 0 to `ROM_DEPTH`-1. Each write carries the ROM word read at that address. No further writes follow.
- R3: In `ST_LOAD` and `ST_RUN` the data RAM read address, write address, write data and write enable equal the processor's `cpu_*` inputs.
- R4: A step pulse sampled in `ST_RUN` at edge e drives the read address to word `OUT_WORD` (default 12) during the next cycle. `out_buf` then holds the word returned from that address from edge e+2 onward.
- R5: The same pass writes `in_buf` into word `IN_WORD` (default 16) at edge e+3 and returns to `ST_RUN`.
- R6: A step pulse that arrives while a refresh pass is in progress is ignored and starts no second pass.
- R7: A processor write enable presented during a refresh pass does not reach the RAM.
- R8: A rising button loads `in_buf` with 0xB0 for `btn[0]`, 0xB1 for `btn[1]` or 0xB2 for `btn[2]`. When several buttons rise together, the lowest index wins.
- R9: `irq` is high for exactly the one cycle after the edge at which a button is first sampled high. Holding a button raises no further pulse.
- R10: `in_buf` keeps only the latest press, so a later press replaces an earlier one that has not yet been pushed to RAM.
- R11: Steps spaced five clocks apart each complete a full pass and mirror the output word written just before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | Processor step pulse |
| btn | input | 3 | Debounced buttons |
| rom_addr | output | ADDR_W | ROM read address |
| rom_data | input | DATA_W | ROM read data (combinational) |
| imem_waddr | output | ADDR_W | Instruction memory write address |
| imem_wdata | output | DATA_W | Instruction memory write data |
| imem_we | output | 1 | Instruction memory write enable |
| cpu_raddr | input | ADDR_W | Processor data read address |
| cpu_waddr | input | ADDR_W | Processor data write address |
| cpu_wdata | input | DATA_W | Processor data write value |
| cpu_we | input | 1 | Processor data write enable |
| ram_raddr | output | ADDR_W | Data RAM read address |
| ram_rdata | input | DATA_W | Data RAM read data, one clock after address |
| ram_waddr | output | ADDR_W | Data RAM write address |
| ram_wdata | output | DATA_W | Data RAM write data |
| ram_we | output | 1 | Data RAM write enable |
| irq | output | 1 | Interrupt request pulse |
| out_buf | output | DATA_W | Output buffer |
| in_buf | output | DATA_W | Input buffer |

## Verification
Take the edge at which a step is sampled as e. The output buffer is due at e+2 and the input word lands in RAM at e+3. A button press shows up on `irq` and `in_buf` one edge after it is first sampled, and `irq` has dropped one edge later. The bench drives inputs and samples results on falling edges. It counts falling edges from the step or press to the exact edge where each result is due, and holds its own RAM model so that mirrored words are read at the ports. The ignored-step and ignored-write cases are judged by a later pass that would expose any stray refresh or stray write.

// File: rtl/mmio_seq_pkg.sv
package mmio_seq_pkg;

    typedef enum logic [2:0] {
        ST_LOAD     = 3'd0,
        ST_RUN      = 3'd1,
        ST_LOAD_OUT = 3'd2,
        ST_SHOW_OUT = 3'd3,
        ST_PUSH_IN  = 3'd4
    } seq_state_e;

    localparam int NUM_BTN = 3;

endpackage

// File: rtl/mmio_seq_btn.sv
module mmio_seq_btn
    import mmio_seq_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int CODE_BASE = 8'hB0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BTN-1:0] btn,
    output logic               irq,
    output logic [DATA_W-1:0]  in_buf
);

    logic [NUM_BTN-1:0] btn_q;
    logic [NUM_BTN-1:0] rise;
    logic [DATA_W-1:0]  code;

    assign rise = btn & ~btn_q;

    // lowest index wins
    always_comb begin
        code = '0;
        for (int i = NUM_BTN - 1; i >= 0; i--) begin
            if (rise[i]) code = DATA_W'(CODE_BASE + i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            btn_q  <= '0;
            irq    <= 1'b0;
            in_buf <= '0;
        end else begin
            btn_q <= btn;
            irq   <= |rise;
            if (|rise) in_buf <= code;
        end
    end

    // R8
    code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (in_buf >= DATA_W'(CODE_BASE)) && (in_buf < DATA_W'(CODE_BASE + NUM_BTN)));

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(rst_n)) |-> |(btn_q & ~$past(btn_q)));

endmodule

// File: rtl/mmio_seq_ctrl.sv
module mmio_seq_ctrl
    import mmio_seq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int ROM_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    output logic [ADDR_W-1:0] load_idx,
    output logic              load_act,
    output logic              own_port,
    output logic              rd_out,
    output logic              cap_out,
    output logic              push_in
);

    localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(ROM_DEPTH - 1);

    seq_state_e state, nxt;
    logic [ADDR_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_LOAD;
            cnt   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_LOAD) cnt <= cnt + 1'b1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_LOAD:     nxt = (cnt == LAST_IDX) ? ST_RUN : ST_LOAD;
            ST_RUN:      nxt = step ? ST_LOAD_OUT : ST_RUN;
            ST_LOAD_OUT: nxt = ST_SHOW_OUT;
            ST_SHOW_OUT: nxt = ST_PUSH_IN;
            ST_PUSH_IN:  nxt = ST_RUN;
            default:     nxt = ST_LOAD;
        endcase
    end

    always_comb begin
        load_idx = cnt;
        load_act = 1'b0;
        own_port = 1'b0;
        rd_out   = 1'b0;
        cap_out  = 1'b0;
        push_in  = 1'b0;
        unique case (state)
            ST_LOAD:     load_act = 1'b1;
            ST_RUN:      ;
            ST_LOAD_OUT: begin own_port = 1'b1; rd_out  = 1'b1; end
            ST_SHOW_OUT: begin own_port = 1'b1; cap_out = 1'b1; end
            ST_PUSH_IN:  begin own_port = 1'b1; push_in = 1'b1; end
            default:     ;
        endcase
    end

    // R2
    load_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_act && $past(load_act) && $past(rst_n)) |-> (load_idx == $past(load_idx) + 1'b1));

    // R4
    seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_out |=> cap_out);

    // R5
    push_after_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_out |=> push_in ##1 (!own_port && !load_act));

    // R6
    start_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_out && $past(rst_n)) |-> ($past(step) && !$past(own_port) && !$past(load_act)));

endmodule

// File: rtl/mmio_seq_port.sv
module mmio_seq_port #(
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int OUT_WORD = 12,
    parameter int IN_WORD  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              own_port,
    input  logic              cap_out,
    input  logic              push_in,
    input  logic [DATA_W-1:0] in_buf,
    input  logic [ADDR_W-1:0] cpu_raddr,
    input  logic [ADDR_W-1:0] cpu_waddr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [ADDR_W-1:0] ram_raddr,
    output logic [ADDR_W-1:0] ram_waddr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    output logic [DATA_W-1:0] out_buf
);

    localparam logic [ADDR_W-1:0] OUT_A = ADDR_W'(OUT_WORD);
    localparam logic [ADDR_W-1:0] IN_A  = ADDR_W'(IN_WORD);

    always_comb begin
        if (own_port) begin
            ram_raddr = OUT_A;
            ram_waddr = IN_A;
            ram_wdata = in_buf;
            ram_we    = push_in;
        end else begin
            ram_raddr = cpu_raddr;
            ram_waddr = cpu_waddr;
            ram_wdata = cpu_wdata;
            ram_we    = cpu_we;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       out_buf <= '0;
        else if (cap_out) out_buf <= ram_rdata;
    end

    // R4
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_out |=> (out_buf == $past(ram_rdata)));

    // R7
    no_cpu_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (own_port && !push_in) |-> !ram_we);

    // R3
    pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !own_port |-> (ram_we == cpu_we) && (ram_raddr == cpu_raddr));

endmodule

// File: rtl/mmio_step_seq.sv
module mmio_step_seq
    import mmio_seq_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int ROM_DEPTH = 16,
    parameter int OUT_WORD  = 12,
    parameter int IN_WORD   = 16,
    parameter int CODE_BASE = 8'hB0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               step,
    input  logic [2:0]         btn,
    output logic [ADDR_W-1:0]  rom_addr,
    input  logic [DATA_W-1:0]  rom_data,
    output logic [ADDR_W-1:0]  imem_waddr,
    output logic [DATA_W-1:0]  imem_wdata,
    output logic               imem_we,
    input  logic [ADDR_W-1:0]  cpu_raddr,
    input  logic [ADDR_W-1:0]  cpu_waddr,
    input  logic [DATA_W-1:0]  cpu_wdata,
    input  logic               cpu_we,
    output logic [ADDR_W-1:0]  ram_raddr,
    input  logic [DATA_W-1:0]  ram_rdata,
    output logic [ADDR_W-1:0]  ram_waddr,
    output logic [DATA_W-1:0]  ram_wdata,
    output logic               ram_we,
    output logic               irq,
    output logic [DATA_W-1:0]  out_buf,
    output logic [DATA_W-1:0]  in_buf
);

    logic [ADDR_W-1:0] load_idx;
    logic load_act, own_port, rd_out, cap_out, push_in;

    mmio_seq_ctrl #(.ADDR_W(ADDR_W), .ROM_DEPTH(ROM_DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .step(step),
        .load_idx(load_idx), .load_act(load_act), .own_port(own_port),
        .rd_out(rd_out), .cap_out(cap_out), .push_in(push_in)
    );

    mmio_seq_btn #(.DATA_W(DATA_W), .CODE_BASE(CODE_BASE)) u_btn (
        .clk(clk), .rst_n(rst_n), .btn(btn), .irq(irq), .in_buf(in_buf)
    );

    mmio_seq_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W),
                    .OUT_WORD(OUT_WORD), .IN_WORD(IN_WORD)) u_port (
        .clk(clk), .rst_n(rst_n), .own_port(own_port), .cap_out(cap_out),
        .push_in(push_in), .in_buf(in_buf),
        .cpu_raddr(cpu_raddr), .cpu_waddr(cpu_waddr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .ram_rdata(ram_rdata),
        .ram_raddr(ram_raddr), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
        .ram_we(ram_we), .out_buf(out_buf)
    );

    assign rom_addr   = load_idx;
    assign imem_waddr = load_idx;
    assign imem_wdata = rom_data;
    assign imem_we    = load_act;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (out_buf == '0) && (in_buf == '0) && !irq);

    // R2
    load_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        imem_we |-> !own_port);

endmodule

// File: tb/tb_mmio_step_seq.sv
module tb_mmio_step_seq;

    localparam int AW = 8;
    localparam int DW = 32;
    localparam int DEPTH = 16;
    localparam int OUTW = 12;
    localparam int INW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step = 1'b0;
    logic [2:0] btn = '0;
    logic [AW-1:0] rom_addr, imem_waddr, ram_raddr, ram_waddr;
    logic [DW-1:0] rom_data, imem_wdata, ram_wdata, out_buf, in_buf;
    logic imem_we, ram_we, irq;
    logic [AW-1:0] cpu_raddr = '0, cpu_waddr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic cpu_we = 1'b0;
    logic [DW-1:0] ram_rdata;
    logic [DW-1:0] mem [0:(1<<AW)-1];

    int n_chk = 0;
    int n_err = 0;
    int ld_cnt = 0;
    int ld_bad = 0;
    logic [DW-1:0] exp_in = '0;

    always #4 clk = ~clk;

    assign rom_data = 32'h5A00_0000 + DW'(rom_addr) * 32'h0101_0003;

    always @(posedge clk) begin
        ram_rdata <= mem[ram_raddr];
        if (ram_we) mem[ram_waddr] <= ram_wdata;
        if (rst_n && imem_we) begin
            ld_cnt <= ld_cnt + 1;
            if (imem_waddr != AW'(ld_cnt) ||
                imem_wdata != 32'h5A00_0000 + DW'(ld_cnt) * 32'h0101_0003)
                ld_bad <= ld_bad + 1;
        end
    end

    mmio_step_seq #(.ADDR_W(AW), .DATA_W(DW), .ROM_DEPTH(DEPTH),
                    .OUT_WORD(OUTW), .IN_WORD(INW)) dut (
        .clk(clk), .rst_n(rst_n), .step(step), .btn(btn),
        .rom_addr(rom_addr), .rom_data(rom_data),
        .imem_waddr(imem_waddr), .imem_wdata(imem_wdata), .imem_we(imem_we),
        .cpu_raddr(cpu_raddr), .cpu_waddr(cpu_waddr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .ram_raddr(ram_raddr), .ram_rdata(ram_rdata),
        .ram_waddr(ram_waddr), .ram_wdata(ram_wdata), .ram_we(ram_we),
        .irq(irq), .out_buf(out_buf), .in_buf(in_buf)
    );

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        cpu_waddr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    // step sampled at edge e; out_buf due after e+2, word IN_WORD after e+3
    task automatic step_check(input logic [DW-1:0] exp_out, input string tag);
        @(negedge clk); step = 1'b1;
        @(negedge clk); step = 1'b0;
        chk(ram_raddr == AW'(OUTW), "R4 read address", DW'(ram_raddr), DW'(OUTW));
        @(negedge clk);
        @(negedge clk);
        chk(out_buf == exp_out, tag, out_buf, exp_out);
        @(negedge clk);
        chk(mem[INW] == exp_in, "R5 input word", mem[INW], exp_in);
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        chk(out_buf == '0, "R1 out_buf", out_buf, '0);
        chk(in_buf == '0, "R1 in_buf", in_buf, '0);
        chk(irq == 1'b0, "R1 irq", DW'(irq), '0);
        rst_n = 1'b1;
        cpu_raddr = 8'd3; cpu_waddr = 8'd7; cpu_wdata = 32'h1234_5678;
        @(negedge clk);
        chk(ram_raddr == 8'd3 && ram_waddr == 8'd7 && ram_wdata == 32'h1234_5678,
            "R3 passthrough in load", DW'(ram_raddr), 32'd3);
        repeat (DEPTH + 2) @(negedge clk);
        chk(ld_cnt == DEPTH, "R2 load count", DW'(ld_cnt), DW'(DEPTH));
        chk(ld_bad == 0, "R2 load content", DW'(ld_bad), '0);
        repeat (4) @(negedge clk);
        chk(ld_cnt == DEPTH, "R2 no extra writes", DW'(ld_cnt), DW'(DEPTH));

        // R3 in RUN
        cpu_raddr = 8'd41; cpu_waddr = 8'd42; cpu_wdata = 32'hCAFE_0001; cpu_we = 1'b1;
        #1;
        chk(ram_raddr == 8'd41 && ram_waddr == 8'd42 && ram_we,
            "R3 passthrough in run", DW'(ram_raddr), 32'd41);
        @(negedge clk); cpu_we = 1'b0;
        chk(mem[42] == 32'hCAFE_0001, "R3 write reaches ram", mem[42], 32'hCAFE_0001);

        // R4 sweep of output values
        for (int i = 0; i < 8; i++) begin
            logic [DW-1:0] v;
            v = (32'h1000_0000 * i) ^ 32'h0000_C0DE ^ (i << 5);
            cpu_write(AW'(OUTW), v);
            step_check(v, "R4 out_buf mirrors word");
        end

        // R8 R9 every rising combination
        for (int m = 1; m < 8; m++) begin
            logic [DW-1:0] c;
            c = m[0] ? 32'hB0 : (m[1] ? 32'hB1 : 32'hB2);
            @(negedge clk); btn = 3'(m);
            @(negedge clk);
            chk(irq == 1'b1, "R9 irq pulse", DW'(irq), 32'd1);
            chk(in_buf == c, "R8 button code", in_buf, c);
            exp_in = c;
            @(negedge clk);
            chk(irq == 1'b0, "R9 irq single cycle while held", DW'(irq), '0);
            @(negedge clk); btn = '0;
            @(negedge clk);
            step_check(mem[OUTW], "R4 out_buf steady");
        end

        // R10 later press replaces earlier
        @(negedge clk); btn = 3'b100;
        @(negedge clk); btn = 3'b000;
        @(negedge clk); btn = 3'b010;
        @(negedge clk);
        chk(in_buf == 32'hB1, "R10 latest press kept", in_buf, 32'hB1);
        btn = 3'b000;
        exp_in = 32'hB1;
        step_check(mem[OUTW], "R10 out_buf steady");

        // R6 step during refresh ignored
        cpu_write(AW'(OUTW), 32'h0000_0A06);
        @(negedge clk); step = 1'b1;
        @(negedge clk); step = 1'b0;
        @(negedge clk); step = 1'b1;
        @(negedge clk); step = 1'b0;
        chk(out_buf == 32'h0000_0A06, "R6 first pass", out_buf, 32'h0000_0A06);
        @(negedge clk);
        cpu_write(AW'(OUTW), 32'h0000_0B06);
        repeat (6) @(negedge clk);
        chk(out_buf == 32'h0000_0A06, "R6 no second pass", out_buf, 32'h0000_0A06);

        // R7 processor write during refresh blocked
        @(negedge clk); step = 1'b1;
        @(negedge clk); step = 1'b0;
        cpu_waddr = AW'(OUTW); cpu_wdata = 32'hDEAD_0007; cpu_we = 1'b1;
        @(negedge clk); cpu_we = 1'b0;
        @(negedge clk);
        chk(out_buf == 32'h0000_0B06, "R7 pass value", out_buf, 32'h0000_0B06);
        @(negedge clk);
        step_check(32'h0000_0B06, "R7 write during refresh ignored");

        // R11 steps five clocks apart
        for (int k = 0; k < 4; k++) begin
            logic [DW-1:0] v;
            v = 32'h5500_0000 + 32'(k * 17);
            @(negedge clk);
            cpu_waddr = AW'(OUTW); cpu_wdata = v; cpu_we = 1'b1;
            step = 1'b1;
            @(negedge clk); cpu_we = 1'b0; step = 1'b0;
            @(negedge clk);
            @(negedge clk);
            chk(out_buf == v, "R11 back-to-back pass", out_buf, v);
            @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule